// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns one PWM reference level into a pair of complementary drive signals for a half bridge. The main output follows the reference and the complementary output follows its inverse. After every change of the reference, the output that is about to switch on is held low for a dead time. The output that is switching off drops in the same cycle. The two outputs are therefore never high together.

The dead time is set by an 8-bit code. The code's top bits choose one of four ranges, and each range has its own offset and step size. Short delays get single-tick resolution, and delays of about a thousand ticks still fit in the same byte. Time is counted in ticks of a base clock enable, so the integrator can slow the dead-time base without touching the block. Each output has its own enable that forces it low. Polarity selection, idle-level forcing and fault shutdown are done downstream.

Top module: `pwm_deadband`

## Requirements
- R1: When `dt_code[7]` is 0, the dead time D is `dt_code[6:0]` ticks (0 to 127).
- R2: When `dt_code[7:6]` is 2'b10, D is (64 + `dt_code[5:0]`) × 2 ticks (128 to 254).
- R3: When `dt_code[7:5]` is 3'b110, D is (32 + `dt_code[4:0]`) × 8 ticks (256 to 504).
- R4: When `dt_code[7:5]` is 3'b111, D is (32 + `dt_code[4:0]`) × 16 ticks (512 to 1008).
- R5: After a reference change, the clock edge that registers the change loads D. The output being switched on goes high once D later clock edges with `tick_en` high have passed. Clock edges with `tick_en` low do not count. The code is sampled only at reference changes.
- R6: On a rising reference, `out_comp` goes low in the same cycle. On a falling reference, `out_main` goes low in the same cycle. `out_main` and `out_comp` are never high together.
- R7: While `main_en` is low, `out_main` stays low. While `comp_en` is low, `out_comp` stays low. Neither enable changes the timing of the other output.
- R8: Every reference change reloads the count, even one that arrives in the cycle holding the last pending tick. A reference pulse shorter than D therefore never raises the delayed output.
- R9: With D = 0, the outputs follow the reference and its inverse in the same cycle as the reference change, with no register in the path.
- R10: While `rst_n` is low, and during the cycle that follows its release, both outputs are low. From the next clock edge on, a reference that was low through reset drives `out_comp` high with no dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | PWM reference level |
| dt_code | input | 8 | Dead-time setup code |
| tick_en | input | 1 | Dead-time base tick; one counted step per clock with this high |
| main_en | input | 1 | Enable for the main output |
| comp_en | input | 1 | Enable for the complementary output |
| out_main | output | 1 | Main output, dead time inserted before each rise |
| out_comp | output | 1 | Complementary output, dead time inserted before each rise |

## Verification
The dangerous coincidence is a reference change landing in the cycle just before the clock edge that would take the counter from one to zero. In that case the reload and the final decrement compete for the same register. The bench provokes this by cutting a pulse after exactly D − 1 counted ticks and then driving the opposite edge. It passes only if the output that was about to rise stays low throughout, and the other output then waits a full fresh D ticks. A second collision is a reference change with D = 0. Here the edge-cycle gating and the counter's expired state must agree within the same cycle. The bench checks this one nanosecond after driving the edge.

// File: rtl/dtg_pkg.sv
// Package dtg_pkg
// Shared constants and types for the dead-time inserter.
// Assumes an 8-bit setup code split into four ranges by its top three bits.
package dtg_pkg;

    localparam int DT_CODE_W  = 8;
    // Step multipliers of the three coarse ranges, written as left shifts.
    localparam int DT_SHIFT_B = 1;
    localparam int DT_SHIFT_C = 3;
    localparam int DT_SHIFT_D = 4;
    // Widest product: a 6-bit base (32 + 31) shifted by the largest step.
    localparam int DT_CNT_W   = 6 + DT_SHIFT_D;

    typedef logic [DT_CNT_W-1:0] dt_count_t;

    typedef enum logic [1:0] {
        RG_FINE = 2'd0,
        RG_X2   = 2'd1,
        RG_X8   = 2'd2,
        RG_X16  = 2'd3
    } dt_range_e;

endpackage

// File: rtl/dtg_code_decode.sv
// Module dtg_code_decode
// Converts the 8-bit setup code into a dead time in base ticks.
// Purely combinational. Assumes the caller samples the result only when
// the reference changes.
module dtg_code_decode
    import dtg_pkg::*;
#(
    parameter int CODE_W  = DT_CODE_W,
    parameter int CNT_W   = DT_CNT_W,
    parameter int SHIFT_B = DT_SHIFT_B,
    parameter int SHIFT_C = DT_SHIFT_C,
    parameter int SHIFT_D = DT_SHIFT_D
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  ticks,
    output logic              is_zero
);

    dt_range_e rng;

    // Pick the range from the leading bits of the code.
    always_comb begin
        if (!code[7])      rng = RG_FINE;
        else if (!code[6]) rng = RG_X2;
        else if (!code[5]) rng = RG_X8;
        else               rng = RG_X16;
    end

    // Offset the base by the range's implicit leading one, then scale it.
    always_comb begin
        unique case (rng)
            RG_FINE: ticks = CNT_W'(code[6:0]);
            RG_X2:   ticks = CNT_W'({1'b1, code[5:0]}) << SHIFT_B;
            RG_X8:   ticks = CNT_W'({1'b1, code[4:0]}) << SHIFT_C;
            default: ticks = CNT_W'({1'b1, code[4:0]}) << SHIFT_D;
        endcase
    end

    // Flag a zero dead time so the output stage can bypass the counter.
    always_comb is_zero = (ticks == '0);

endmodule

// File: rtl/dtg_edge_track.sv
// Module dtg_edge_track
// Registers the reference level, flags a change in the current cycle and
// raises a run flag one clock after reset release.
// Assumes ref_in is already synchronous to clk.
module dtg_edge_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic edge_hit,
    output logic run
);

    logic ref_q;

    // Keep the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_in;
    end

    // Hold the outputs quiet until the first clock edge after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= 1'b1;
    end

    // A change is visible in the same cycle the reference moves.
    always_comb edge_hit = (ref_in != ref_q);

endmodule

// File: rtl/dtg_dead_counter.sv
// Module dtg_dead_counter
// Down-counter for the dead time. A load wins over a tick. The counter
// stops at zero and reports expiry there.
// Assumes load_val is stable in the cycle the load is asserted.
module dtg_dead_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] remain;

    // Reload on every reference change, otherwise step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                    remain <= '0;
        else if (load)                 remain <= load_val;
        else if (tick && remain != '0) remain <= remain - 1'b1;
    end

    // The gate may open once nothing is left to count.
    always_comb expired = (remain == '0);

endmodule

// File: rtl/dtg_out_gate.sv
// Module dtg_out_gate
// Forms the two complementary outputs from the reference, the gate state
// and the per-output enables.
// Assumes edge_hit and expired come from the same clock domain as ref_in.
module dtg_out_gate (
    input  logic ref_in,
    input  logic edge_hit,
    input  logic zero_dt,
    input  logic expired,
    input  logic run,
    input  logic main_en,
    input  logic comp_en,
    output logic out_main,
    output logic out_comp
);

    logic open_gate;

    // In an edge cycle only a zero dead time may open, else wait for expiry.
    always_comb open_gate = run && (edge_hit ? zero_dt : expired);

    // Steer the open gate to the side the reference selects.
    always_comb begin
        out_main = open_gate &&  ref_in && main_en;
        out_comp = open_gate && !ref_in && comp_en;
    end

endmodule

// File: rtl/pwm_deadband.sv
// Module pwm_deadband
// Complementary PWM output pair with a programmable dead time inserted
// before each output turns on.
// Assumes all inputs are synchronous to clk. dt_code is used only in the
// cycle the reference changes.
module pwm_deadband
    import dtg_pkg::*;
#(
    parameter int CODE_W = DT_CODE_W,
    parameter int CNT_W  = DT_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic [CODE_W-1:0] dt_code,
    input  logic              tick_en,
    input  logic              main_en,
    input  logic              comp_en,
    output logic              out_main,
    output logic              out_comp
);

    logic [CNT_W-1:0] dt_ticks;
    logic             dt_zero;
    logic             edge_hit;
    logic             run;
    logic             expired;

    dtg_code_decode #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .code    (dt_code),
        .ticks   (dt_ticks),
        .is_zero (dt_zero)
    );

    dtg_edge_track u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .edge_hit (edge_hit),
        .run      (run)
    );

    dtg_dead_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (edge_hit),
        .load_val (dt_ticks),
        .tick     (tick_en),
        .expired  (expired)
    );

    dtg_out_gate u_gate (
        .ref_in   (ref_in),
        .edge_hit (edge_hit),
        .zero_dt  (dt_zero),
        .expired  (expired),
        .run      (run),
        .main_en  (main_en),
        .comp_en  (comp_en),
        .out_main (out_main),
        .out_comp (out_comp)
    );

endmodule

// File: rtl/pwm_deadband_chk.sv
// Module pwm_deadband_chk
// Property checker attached to pwm_deadband through bind.
module pwm_deadband_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_in,
    input logic [7:0] dt_code,
    input logic       main_en,
    input logic       comp_en,
    input logic       out_main,
    input logic       out_comp
);

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_main && out_comp));

    p_main_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !main_en |-> !out_main);

    p_comp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_en |-> !out_comp);

    p_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_in) && dt_code != 8'd0) |-> !out_main);

    p_rise_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ref_in) && dt_code != 8'd0) |=> !out_main);

    p_fall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_in) && dt_code != 8'd0) |-> !out_comp);

    p_fall_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_in) |-> !out_main);

endmodule

bind pwm_deadband pwm_deadband_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .dt_code  (dt_code),
    .main_en  (main_en),
    .comp_en  (comp_en),
    .out_main (out_main),
    .out_comp (out_comp)
);

// File: tb/sim_pwm_deadband.sv
// Directed bench for pwm_deadband. Inputs change and outputs are sampled
// at the falling clock edge.
module sim_pwm_deadband;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [7:0] dt_code = 8'd0;
    logic       tick_en = 1'b1;
    logic       main_en = 1'b1;
    logic       comp_en = 1'b1;
    logic       out_main;
    logic       out_comp;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwm_deadband u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .dt_code  (dt_code),
        .tick_en  (tick_en),
        .main_en  (main_en),
        .comp_en  (comp_en),
        .out_main (out_main),
        .out_comp (out_comp)
    );

    // Dead time in ticks, taken from R1 to R4.
    function automatic int exp_delay(input logic [7:0] c);
        if (!c[7])      return int'(c[6:0]);
        else if (!c[6]) return (64 + int'(c[5:0])) * 2;
        else if (!c[5]) return (32 + int'(c[4:0])) * 8;
        else            return (32 + int'(c[4:0])) * 16;
    endfunction

    task automatic report(input string req, input bit ok, input int act,
                          input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Flip the reference with the given code and follow the delayed output.
    // A nonzero cut ends the window early so that the next call flips again.
    task automatic measure(input logic [7:0] code, input int period,
                           input int cut, input string req);
        logic lvl;
        logic en;
        logic act_d;
        logic act_o;
        logic exp_d;
        int   dly;
        int   n;
        int   ticks;
        int   bad_k;
        int   fa;
        int   fe;
        lvl   = !ref_in;
        dly   = exp_delay(code);
        ticks = 0;
        bad_k = 0;
        fa    = 0;
        fe    = 0;
        dt_code = code;
        ref_in  = lvl;
        tick_en = (period == 1);
        #1;
        en    = lvl ? main_en : comp_en;
        act_d = lvl ? out_main : out_comp;
        act_o = lvl ? out_comp : out_main;
        exp_d = en && (dly == 0);
        report(req, (act_d === exp_d) && (act_o === 1'b0),
               int'({act_d, act_o}), int'({exp_d, 1'b0}), "edge cycle");
        n = (cut > 0) ? cut : (dly + 2) * period + 2;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            if (k > 1 && tick_en) ticks++;
            @(negedge clk);
            exp_d = en && (ticks >= dly);
            act_d = lvl ? out_main : out_comp;
            act_o = lvl ? out_comp : out_main;
            if (((act_d !== exp_d) || (act_o !== 1'b0)) && bad_k == 0) begin
                bad_k = k;
                fa = int'({act_d, act_o});
                fe = int'({exp_d, 1'b0});
            end
            tick_en = (period == 1) || ((k % period) == 0);
        end
        report(req, bad_k == 0, fa, fe,
               $sformatf("window code=%0h first bad cycle %0d", code, bad_k));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        report("R10", !out_main && !out_comp, int'({out_main, out_comp}), 0, "in reset");
        rst_n = 1'b1;
        #1;
        report("R10", !out_main && !out_comp, int'({out_main, out_comp}), 0, "release cycle");
        @(negedge clk);
        report("R10", !out_main && out_comp, int'({out_main, out_comp}), 1, "after release");
    endtask

    task automatic t_fine;
        measure(8'h05, 1, 0, "R1 fine rise");
        measure(8'h05, 1, 0, "R1 fine fall");
        measure(8'h7F, 1, 0, "R1 fine max");
        measure(8'h01, 1, 0, "R1 fine min");
    endtask

    task automatic t_coarse;
        measure(8'h80, 1, 0, "R2 low end");
        measure(8'hBF, 1, 0, "R2 high end");
        measure(8'hC0, 1, 0, "R3 low end");
        measure(8'hC5, 1, 0, "R3 mid");
        measure(8'hE0, 1, 0, "R4 low end");
        measure(8'hFF, 1, 0, "R4 high end");
    endtask

    task automatic t_gated_tick;
        measure(8'h03, 3, 0, "R5 gated tick");
        measure(8'h04, 4, 0, "R5 gated tick");
    endtask

    task automatic t_zero;
        measure(8'h00, 1, 0, "R9 zero rise");
        measure(8'h00, 1, 0, "R9 zero fall");
    endtask

    task automatic t_enables;
        main_en = 1'b0;
        measure(8'h02, 1, 0, "R7 main disabled");
        measure(8'h02, 1, 0, "R7 comp unaffected");
        main_en = 1'b1;
        comp_en = 1'b0;
        measure(8'h02, 1, 0, "R7 main unaffected");
        measure(8'h02, 1, 0, "R7 comp disabled");
        comp_en = 1'b1;
    endtask

    task automatic t_restart;
        measure(8'h0A, 1, 4, "R8 short pulse");
        measure(8'h0A, 1, 0, "R8 reload after short");
        measure(8'h0A, 1, 10, "R8 edge on last tick");
        measure(8'h0A, 1, 0, "R8 reload after collision");
        measure(8'h06, 1, 0, "R6 rise");
        measure(8'h06, 1, 0, "R6 fall");
    endtask

    initial begin
        t_reset();
        t_fine();
        t_coarse();
        t_gated_tick();
        t_zero();
        t_enables();
        t_restart();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule